// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one DMA channel. It moves a run of elements between a device register, whose address never changes, and a memory buffer, whose address steps forward by the element width after each element. A transfer is described by four 32-bit values: device address, memory address, size word and link word. The channel runs in one of two modes. In single mode it executes the one descriptor presented on its input ports. In chained mode it reads descriptors from memory and follows the links from one to the next.

All traffic goes through one 32-bit request/acknowledge memory port. That traffic is the descriptor fetches and, for every element, one read of the source followed by one write of the destination. Before each element the channel waits for the device to raise its request line. A 2-bit state output shows what the channel is doing. A one-cycle done pulse marks the end of a descriptor that asks for an interrupt, and the end of the whole run. An error pulse, given together with done, marks a descriptor that was refused.

Top module: `desc_dma_channel`

## Requirements
- R1: After reset the state output is 0, done and error are low and no memory request is made. While the state is 0 the memory port stays quiet.
- R2: The state output reads 1 while descriptor words are fetched, 2 while waiting for the device, and 3 while an element is read or written. In state 2 no memory request is made, and the channel stays in state 2 until devReq is high.
- R3: In single mode (sgMode=0 at start) the channel runs the descriptor given on regDevAddr, regMemAddr, regSize and regNext, sampled in the cycle start is high. It reads no descriptor from memory.
- R4: When toDevice=1, each element is read from the memory address and written, unchanged, to the device address. When toDevice=0, each element is read from the device address and written to the memory address. Each element is one read handshake followed by one write handshake.
- R5: Size word bits [13:12] give the element width: code 3 is 1 byte, code 2 is 2 bytes and code 0 is 4 bytes. Bits [11:0] give the element count. The memory address grows by the width after each element, and the device address stays fixed.
- R6: In chained mode the first descriptor is at regNext with bits [1:0] cleared. Its four words are read at ascending word addresses, in the order device address, memory address, size, link.
- R7: Link word bit 1 means "follow" and bit 0 means "interrupt". In chained mode a set follow bit makes the channel fetch the next descriptor from the link address with bits [1:0] cleared. In single mode the follow bit is ignored.
- R8: done is high for one cycle, in the cycle after the last write handshake of a descriptor, when that descriptor's interrupt bit is set or when it ends the run.
- R9: A descriptor whose width code is 1, whose count is 0, or whose count is above 0x3FF (1- or 2-byte width) or above 0x7FF (4-byte width) is refused. The channel moves no data for it, pulses error and done in the same cycle, and returns to state 0. Counts of 0x3FF (2-byte) and 0x7FF (4-byte) are accepted.
- R10: A memory request keeps its address and write flag unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken only in state 0) |
| sgMode | input | 1 | 1 = chained descriptors from memory, 0 = single descriptor from inputs |
| toDevice | input | 1 | 1 = memory to device, 0 = device to memory |
| regDevAddr | input | 32 | Device address for single mode |
| regMemAddr | input | 32 | Memory start address for single mode |
| regSize | input | 32 | Size word: width code [13:12], count [11:0] |
| regNext | input | 32 | Link word; in chained mode, the address of the first descriptor |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Byte address of the access |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Access acknowledge; read data is valid with it |
| memRdata | input | 32 | Read data |
| devReq | input | 1 | Device ready for the next element |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle refusal pulse, given with done |
| state | output | 2 | 0 idle, 1 fetching, 2 waiting for device, 3 transferring |

## Verification
The bench aims at the size limits on both sides of each width's boundary, at count zero and at width code 1. A design with a wrong comparison would either start a long transfer it should refuse, or refuse a legal 0x3FF or 0x7FF run. Chains are run with every link code. A design that ignores the interrupt bit, or that follows links in single mode, gives the wrong number of done pulses or shows fetches that were never expected. A chain whose second descriptor is bad checks that data from the first descriptor is still delivered before the error. Holding devReq low checks that a design which does not wait for the device is caught by the memory traffic it makes in state 2.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W = 12;
  localparam int WCODE_LSB = 12;

  typedef enum logic [1:0] {SEL_FETCH, SEL_READ, SEL_WRITE} busSel_e;

  typedef struct packed {
    logic accept;
    logic loadRegs;
    logic ptrFromReg;
    logic ptrFromNext;
    logic takeWord;
    logic takeData;
    logic stepElem;
  } ctrlStrobes_t;

  function automatic logic [2:0] widthBytes(input logic [1:0] code);
    case (code)
      2'd3: widthBytes = 3'd1;
      2'd2: widthBytes = 3'd2;
      default: widthBytes = 3'd4;
    endcase
  endfunction

  function automatic logic descBad(input logic [1:0] code, input logic [CNT_W-1:0] cnt,
                                   input logic [CNT_W-1:0] maxNarrow,
                                   input logic [CNT_W-1:0] maxWide);
    descBad = (code == 2'd1) || (cnt == '0) ||
              ((code == 2'd0) ? (cnt > maxWide) : (cnt > maxNarrow));
  endfunction
endpackage

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_chan_pkg::*;
#(
  parameter logic [CNT_W-1:0] MAX_NARROW = 12'h3FF,
  parameter logic [CNT_W-1:0] MAX_WIDE = 12'h7FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      stb,
  input  busSel_e           busSel,
  input  logic              toDevice,
  input  logic [DATA_W-1:0] regDevAddr,
  input  logic [DATA_W-1:0] regMemAddr,
  input  logic [DATA_W-1:0] regSize,
  input  logic [DATA_W-1:0] regNext,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              wordLast,
  output logic              countLast,
  output logic              badIn,
  output logic              badLatched,
  output logic              followBit,
  output logic              irqBit
);
  logic [DATA_W-1:0] devQ, memQ, nextQ, ptrQ, dataQ;
  logic [1:0] codeQ, wordIdx;
  logic [CNT_W-1:0] countQ;
  logic dirQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      devQ <= '0; memQ <= '0; nextQ <= '0; ptrQ <= '0; dataQ <= '0;
      codeQ <= '0; wordIdx <= '0; countQ <= '0; dirQ <= 1'b0;
    end else begin
      if (stb.accept) dirQ <= toDevice;
      if (stb.loadRegs) begin
        devQ <= regDevAddr;
        memQ <= regMemAddr;
        codeQ <= regSize[WCODE_LSB+1:WCODE_LSB];
        countQ <= regSize[CNT_W-1:0];
        nextQ <= regNext;
      end
      if (stb.ptrFromReg) begin
        ptrQ <= {regNext[DATA_W-1:2], 2'b00};
        wordIdx <= '0;
      end
      if (stb.ptrFromNext) begin
        ptrQ <= {nextQ[DATA_W-1:2], 2'b00};
        wordIdx <= '0;
      end
      if (stb.takeWord) begin
        case (wordIdx)
          2'd0: devQ <= memRdata;
          2'd1: memQ <= memRdata;
          2'd2: begin
            codeQ <= memRdata[WCODE_LSB+1:WCODE_LSB];
            countQ <= memRdata[CNT_W-1:0];
          end
          default: nextQ <= memRdata;
        endcase
        wordIdx <= wordIdx + 2'd1;
        ptrQ <= ptrQ + DATA_W'(4);
      end
      if (stb.takeData) dataQ <= memRdata;
      if (stb.stepElem) begin
        countQ <= countQ - 1'b1;
        memQ <= memQ + DATA_W'(widthBytes(codeQ));
      end
    end
  end

  always_comb begin
    case (busSel)
      SEL_READ: memAddr = dirQ ? memQ : devQ;
      SEL_WRITE: memAddr = dirQ ? devQ : memQ;
      default: memAddr = ptrQ;
    endcase
  end

  assign memWdata = dataQ;
  assign wordLast = (wordIdx == 2'd3);
  assign countLast = (countQ == CNT_W'(1));
  assign followBit = nextQ[1];
  assign irqBit = nextQ[0];
  assign badLatched = descBad(codeQ, countQ, MAX_NARROW, MAX_WIDE);
  assign badIn = descBad(regSize[WCODE_LSB+1:WCODE_LSB], regSize[CNT_W-1:0],
                         MAX_NARROW, MAX_WIDE);
endmodule

// File: rtl/dma_control.sv
module dma_control
  import dma_chan_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         sgMode,
  input  logic         devReq,
  input  logic         memAck,
  input  logic         wordLast,
  input  logic         countLast,
  input  logic         badIn,
  input  logic         badLatched,
  input  logic         followBit,
  input  logic         irqBit,
  output ctrlStrobes_t stb,
  output busSel_e      busSel,
  output logic         memReq,
  output logic         memWe,
  output logic         done,
  output logic         error,
  output logic [1:0]   state
);
  typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_WAIT, ST_READ, ST_WRITE} ctlState_e;
  ctlState_e cur, nxt;
  logic sgQ, doneSet, errSet, chainOn;

  always_comb begin
    stb = '0;
    busSel = SEL_FETCH;
    memReq = 1'b0;
    memWe = 1'b0;
    nxt = cur;
    doneSet = 1'b0;
    errSet = 1'b0;
    chainOn = sgQ && followBit;
    case (cur)
      ST_IDLE: if (start) begin
        stb.accept = 1'b1;
        if (sgMode) begin
          stb.ptrFromReg = 1'b1;
          nxt = ST_FETCH;
        end else begin
          stb.loadRegs = 1'b1;
          if (badIn) begin
            doneSet = 1'b1;
            errSet = 1'b1;
          end else nxt = ST_WAIT;
        end
      end
      ST_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          stb.takeWord = 1'b1;
          if (wordLast) begin
            if (badLatched) begin
              doneSet = 1'b1;
              errSet = 1'b1;
              nxt = ST_IDLE;
            end else nxt = ST_WAIT;
          end
        end
      end
      ST_WAIT: if (devReq) nxt = ST_READ;
      ST_READ: begin
        memReq = 1'b1;
        busSel = SEL_READ;
        if (memAck) begin
          stb.takeData = 1'b1;
          nxt = ST_WRITE;
        end
      end
      default: begin
        memReq = 1'b1;
        memWe = 1'b1;
        busSel = SEL_WRITE;
        if (memAck) begin
          stb.stepElem = 1'b1;
          if (countLast) begin
            doneSet = irqBit || !chainOn;
            if (chainOn) begin
              stb.ptrFromNext = 1'b1;
              nxt = ST_FETCH;
            end else nxt = ST_IDLE;
          end else nxt = ST_WAIT;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cur <= ST_IDLE;
      sgQ <= 1'b0;
      done <= 1'b0;
      error <= 1'b0;
    end else begin
      cur <= nxt;
      done <= doneSet;
      error <= errSet;
      if (stb.accept) sgQ <= sgMode;
    end
  end

  always_comb begin
    case (cur)
      ST_IDLE: state = 2'd0;
      ST_FETCH: state = 2'd1;
      ST_WAIT: state = 2'd2;
      default: state = 2'd3;
    endcase
  end
endmodule

// File: rtl/desc_dma_channel.sv
module desc_dma_channel
  import dma_chan_pkg::*;
#(
  parameter logic [CNT_W-1:0] MAX_NARROW = 12'h3FF,
  parameter logic [CNT_W-1:0] MAX_WIDE = 12'h7FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              sgMode,
  input  logic              toDevice,
  input  logic [DATA_W-1:0] regDevAddr,
  input  logic [DATA_W-1:0] regMemAddr,
  input  logic [DATA_W-1:0] regSize,
  input  logic [DATA_W-1:0] regNext,
  output logic              memReq,
  output logic              memWe,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              devReq,
  output logic              done,
  output logic              error,
  output logic [1:0]        state
);
  ctrlStrobes_t stb;
  busSel_e busSel;
  logic wordLast, countLast, badIn, badLatched, followBit, irqBit;

  dma_control i_ctl (
    .clk(clk), .rstN(rstN), .start(start), .sgMode(sgMode), .devReq(devReq),
    .memAck(memAck), .wordLast(wordLast), .countLast(countLast), .badIn(badIn),
    .badLatched(badLatched), .followBit(followBit), .irqBit(irqBit), .stb(stb),
    .busSel(busSel), .memReq(memReq), .memWe(memWe), .done(done), .error(error),
    .state(state)
  );

  dma_datapath #(.MAX_NARROW(MAX_NARROW), .MAX_WIDE(MAX_WIDE)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busSel(busSel), .toDevice(toDevice),
    .regDevAddr(regDevAddr), .regMemAddr(regMemAddr), .regSize(regSize),
    .regNext(regNext), .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .wordLast(wordLast), .countLast(countLast), .badIn(badIn), .badLatched(badLatched),
    .followBit(followBit), .irqBit(irqBit)
  );
endmodule

// File: rtl/desc_dma_channel_chk.sv
module desc_dma_channel_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        memReq,
  input logic        memWe,
  input logic [31:0] memAddr,
  input logic        memAck,
  input logic        devReq,
  input logic        done,
  input logic        error,
  input logic [1:0]  state
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    state == 2'd0 |-> !memReq);
  p_wait_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    state == 2'd2 |-> !memReq);
  p_wait_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    state == 2'd2 && !devReq |=> state == 2'd2);
  p_fetch_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    state == 2'd1 |-> memReq && !memWe);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> !done);
  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));
endmodule

bind desc_dma_channel desc_dma_channel_chk i_chk (
  .clk(clk), .rstN(rstN), .start(start), .memReq(memReq), .memWe(memWe),
  .memAddr(memAddr), .memAck(memAck), .devReq(devReq), .done(done),
  .error(error), .state(state)
);

// File: tb/test_desc_dma_channel.sv
`timescale 1ns/1ps
module test_desc_dma_channel;
  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, sgMode = 1'b0, toDevice = 1'b0;
  logic [31:0] regDevAddr = '0, regMemAddr = '0, regSize = '0, regNext = '0;
  logic memReq, memWe, memAck, devReq = 1'b1, done, error;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [1:0] state;

  int total = 0, bad = 0, doneSeen = 0, errSeen = 0;
  bit sawFetch = 0, sawXfer = 0, finished = 0;
  logic [63:0] expWr[$];
  logic [31:0] expFetch[$];
  logic [31:0] dmem [0:63];

  always #2.5 clk = ~clk;

  desc_dma_channel i_desc_dma_channel (.*);

  function automatic logic [31:0] rdModel(input logic [31:0] a);
    if (a < 32'h100) return dmem[a[7:2]];
    return {a[15:0], ~a[15:0]};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      memAck <= 1'b0;
      memRdata <= '0;
    end else begin
      memAck <= memReq && !memAck;
      if (memReq && !memAck) memRdata <= rdModel(memAddr);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: scoreboard pops
  always @(negedge clk) if (rstN) begin
    if (done) doneSeen++;
    if (error) errSeen++;
    if (state == 2'd1) sawFetch = 1;
    if (state == 2'd3 && memReq) sawXfer = 1;
    if (memReq && memAck && memWe) begin
      if (expWr.size() == 0) chk(0, "R4/R9", "unexpected write", {memAddr, memWdata}, 0);
      else begin
        logic [63:0] e;
        e = expWr.pop_front();
        chk({memAddr, memWdata} == e, "R4/R5", "write addr+data", {memAddr, memWdata}, e);
      end
    end
    if (memReq && memAck && !memWe && state == 2'd1) begin
      if (expFetch.size() == 0) chk(0, "R3/R6", "unexpected fetch", memAddr, 0);
      else begin
        logic [31:0] f;
        f = expFetch.pop_front();
        chk(memAddr == f, "R6", "fetch address", memAddr, f);
      end
    end
  end

  task automatic pushElems(input logic [31:0] dev, input logic [31:0] mem,
                           input logic [1:0] code, input int cnt, input bit toDev);
    int w;
    w = (code == 2'd3) ? 1 : (code == 2'd2) ? 2 : 4;
    for (int i = 0; i < cnt; i++) begin
      logic [31:0] a;
      a = mem + 32'(i * w);
      if (toDev) expWr.push_back({dev, rdModel(a)});
      else expWr.push_back({a, rdModel(dev)});
    end
  endtask

  task automatic putDesc(input logic [31:0] base, input logic [31:0] dev,
                         input logic [31:0] mem, input logic [31:0] size,
                         input logic [31:0] nxt);
    dmem[base[7:2]] = dev;
    dmem[base[7:2] + 6'd1] = mem;
    dmem[base[7:2] + 6'd2] = size;
    dmem[base[7:2] + 6'd3] = nxt;
    for (int k = 0; k < 4; k++) expFetch.push_back(base + 32'(4 * k));
  endtask

  task automatic launch(input bit sg, input bit toDev, input logic [31:0] dev,
                        input logic [31:0] mem, input logic [31:0] size,
                        input logic [31:0] nxt);
    @(negedge clk);
    doneSeen = 0; errSeen = 0; sawFetch = 0; sawXfer = 0;
    sgMode = sg; toDevice = toDev; regDevAddr = dev; regMemAddr = mem;
    regSize = size; regNext = nxt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    regDevAddr = 32'hDEAD0000; regMemAddr = 32'hDEAD0000; regSize = '0; regNext = '0;
  endtask

  task automatic finish(input string req, input int expDone, input int expErr);
    int n;
    n = 0;
    while (doneSeen < expDone && n < 30000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
    chk(doneSeen == expDone, req, "done pulses (R8)", doneSeen, expDone);
    chk(errSeen == expErr, req, "error pulses (R9)", errSeen, expErr);
    chk(expWr.size() == 0, req, "writes left over", expWr.size(), 0);
    chk(expFetch.size() == 0, req, "fetches left over", expFetch.size(), 0);
    chk(state == 2'd0, req, "state back to idle (R1)", state, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(state == 2'd0 && !done && !error && !memReq, "R1", "reset outputs",
        {state, done, error, memReq}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(state == 2'd0 && !memReq, "R1", "idle after reset", {state, memReq}, 0);

    // R3 R4 R5: single mode, memory to device, 4-byte, count 3
    pushElems(32'h0000_0800, 32'h0000_1000, 2'd0, 3, 1);
    launch(0, 1, 32'h0000_0800, 32'h0000_1000, 32'h0000_0003, 32'h0);
    finish("R3", 1, 0);
    chk(sawXfer, "R2", "state 3 seen during transfer", sawXfer, 1);
    chk(!sawFetch, "R3", "no fetch state in single mode", sawFetch, 0);

    // R7: single mode ignores follow bit, 1-byte, device to memory
    pushElems(32'h0000_0900, 32'h0000_2001, 2'd3, 5, 0);
    launch(0, 0, 32'h0000_0900, 32'h0000_2001, 32'h0000_3005, 32'h0000_0043);
    finish("R7", 1, 0);

    // R2: wait for device request
    devReq = 1'b0;
    pushElems(32'h0000_0A00, 32'h0000_3000, 2'd2, 2, 0);
    launch(0, 0, 32'h0000_0A00, 32'h0000_3000, 32'h0000_2002, 32'h1);
    repeat (6) @(negedge clk);
    chk(state == 2'd2, "R2", "state held in wait", state, 2);
    chk(!memReq, "R2", "no request while waiting", memReq, 0);
    chk(expWr.size() == 2, "R2", "no element moved before devReq", expWr.size(), 2);
    devReq = 1'b1;
    finish("R2", 1, 0);

    // R6 R7 R8: chain, follow without interrupt then last with interrupt
    putDesc(32'h20, 32'h0000_0B00, 32'h0000_4000, 32'h0000_2002, 32'h0000_0042);
    putDesc(32'h40, 32'h0000_0B00, 32'h0000_4100, 32'h0000_0003, 32'h0000_0001);
    pushElems(32'h0000_0B00, 32'h0000_4000, 2'd2, 2, 1);
    pushElems(32'h0000_0B00, 32'h0000_4100, 2'd0, 3, 1);
    launch(1, 1, 32'h0, 32'h0, 32'h0, 32'h0000_0022);
    finish("R6", 1, 0);
    chk(sawFetch, "R2", "state 1 seen during fetch", sawFetch, 1);

    // R7 R8: follow with interrupt then last without interrupt: two done pulses
    putDesc(32'h80, 32'h0000_0C00, 32'h0000_5000, 32'h0000_3002, 32'h0000_00A3);
    putDesc(32'hA0, 32'h0000_0C00, 32'h0000_5100, 32'h0000_2001, 32'h0000_0000);
    pushElems(32'h0000_0C00, 32'h0000_5000, 2'd3, 2, 0);
    pushElems(32'h0000_0C00, 32'h0000_5100, 2'd2, 1, 0);
    launch(1, 0, 32'h0, 32'h0, 32'h0, 32'h0000_0080);
    finish("R8", 2, 0);

    // R9: refused descriptors in single mode
    launch(0, 1, 32'h0000_0D00, 32'h0000_6000, 32'h0000_1004, 32'h0);
    finish("R9 width code 1", 1, 1);
    launch(0, 1, 32'h0000_0D00, 32'h0000_6000, 32'h0000_0000, 32'h0);
    finish("R9 count 0", 1, 1);
    launch(0, 1, 32'h0000_0D00, 32'h0000_6000, 32'h0000_3400, 32'h0);
    finish("R9 1-byte 0x400", 1, 1);
    launch(0, 1, 32'h0000_0D00, 32'h0000_6000, 32'h0000_2400, 32'h0);
    finish("R9 2-byte 0x400", 1, 1);
    launch(0, 1, 32'h0000_0D00, 32'h0000_6000, 32'h0000_0800, 32'h0);
    finish("R9 4-byte 0x800", 1, 1);

    // R9: limits accepted
    pushElems(32'h0000_0E00, 32'h0000_7000, 2'd2, 32'h3FF, 1);
    launch(0, 1, 32'h0000_0E00, 32'h0000_7000, 32'h0000_23FF, 32'h0);
    finish("R9 2-byte 0x3FF", 1, 0);
    pushElems(32'h0000_0E00, 32'h0001_0000, 2'd0, 32'h7FF, 0);
    launch(0, 0, 32'h0000_0E00, 32'h0001_0000, 32'h0000_07FF, 32'h0);
    finish("R9 4-byte 0x7FF", 1, 0);

    // R9: second descriptor of a chain refused after first delivered
    putDesc(32'hC0, 32'h0000_0F00, 32'h0000_9000, 32'h0000_0002, 32'h0000_00E2);
    putDesc(32'hE0, 32'h0000_0F00, 32'h0000_9100, 32'h0000_1002, 32'h0000_0001);
    pushElems(32'h0000_0F00, 32'h0000_9000, 2'd0, 2, 1);
    launch(1, 1, 32'h0, 32'h0, 32'h0, 32'h0000_00C0);
    finish("R9 chain", 1, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule